// File: doc/BRIEF.md
# Dual-Path Nested Interrupt Controller

This controller gathers twenty-six peripheral request lines and one request raised only by software into a single 28-bit source vector. Position 0 is reserved for a summary flag, position 1 is the software request, and positions 2 to 27 are the hardware lines. Every source carries two independent enable bits. One routes the source to the normal interrupt request output and the other routes it to the fast interrupt request output. Software sets and clears these enable bits through write-one registers on a single-cycle register port.

For each path a status word reports the sources that are both active and enabled. On the fast path, position 0 of that word is a summary flag. Each source has a 3-bit priority level that software can program. When software turns on nesting, the normal request output fires only while the most urgent pending level lies above the level currently being serviced. That level is tracked on an eight-entry stack: the processor pushes it with an acknowledge pulse and pops it with an end-of-interrupt write.

Register offsets on `addr`:

| Offset | Name | Effect of a write | Value on a read |
|---|---|---|---|
| 0 | IRQ enable-set | each 1 bit sets that enable | IRQ enables |
| 1 | IRQ enable-clear | each 1 bit clears that enable | IRQ enables |
| 2 | FIQ enable-set | each 1 bit sets that enable | FIQ enables |
| 3 | FIQ enable-clear | each 1 bit clears that enable | FIQ enables |
| 4 | IRQ status | none | IRQ status word |
| 5 | FIQ status | none | FIQ status word |
| 6 | software set | `wdata[1]`=1 raises the software request | software request in bit 1 |
| 7 | software clear | `wdata[1]`=1 drops the software request | software request in bit 1 |
| 8 | control | `wdata[0]` sets the nesting enable | nesting enable in bit 0 |
| 9 | end-of-interrupt | pops the stack | 0 |
| 10 | priority | `wdata[4:0]` selects a source, `wdata[10:8]` gives its level | stack depth in `[3:0]`, top level in `[6:4]` |

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, both enable words read 0, the software request is 0, the nesting enable is 0, the stack depth reads 0, and `irq_out` and `fiq_out` are low.
- R2: A write to an enable-set offset (0 or 2) sets every enable bit whose `wdata` bit is 1. A write to an enable-clear offset (1 or 3) clears every such bit. Bits written as 0 keep their value. Enable bit 0 always reads 0 on both paths.
- R3: The software request (bit 1) rises only when `wdata[1]`=1 is written to offset 6 and falls only when `wdata[1]`=1 is written to offset 7. `hw_irq[1]` and `hw_irq[0]` have no effect on any status word or output.
- R4: The IRQ status word (offset 4) equals the active sources ANDed with the IRQ enables, and its bit 0 is always 0.
- R5: In the FIQ status word (offset 5), bits 27:1 equal the active sources ANDed with the FIQ enables, and bit 0 is the OR of bits 27:1.
- R6: `fiq_out` is high in the cycle after any FIQ status bit is set, and low in the cycle after none is set.
- R7: With nesting off, `irq_out` is high in the cycle after any IRQ status bit is set, and low in the cycle after none is set.
- R8: With nesting on, `irq_out` is high in the cycle after the highest level among the set IRQ status bits exceeds the current level. When the stack is empty, any set IRQ status bit counts as exceeding it. Level 7 is the most urgent.
- R9: With nesting on, an `ack` pulse while some IRQ status bit is set pushes the highest pending level. A write to offset 9 pops the stack. A push at depth 8 and a pop at depth 0 are ignored. When a push and a pop come in the same cycle, only the pop is applied.
- R10: While nesting is off, `ack` leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | 28 | Peripheral request levels; bits 1:0 are ignored |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| ack | input | 1 | Acknowledge pulse from the processor that pushes the current level |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |

## Verification
The checker assumes that `hw_irq` and the register port change only between clock edges and hold steady across each edge, so that every registered output reflects the status word from one cycle earlier. It also assumes that `ack` is a pulse issued by the processor and may arrive while the stack is full. The stimulus drives all inputs on falling edges and holds each peripheral line as a level. It issues deliberate excess acknowledges and end-of-interrupt writes so that both stack limits are reached inside these assumptions.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic [3:0] {
    A_IRQ_SET  = 4'd0,
    A_IRQ_CLR  = 4'd1,
    A_FIQ_SET  = 4'd2,
    A_FIQ_CLR  = 4'd3,
    A_IRQ_STAT = 4'd4,
    A_FIQ_STAT = 4'd5,
    A_SW_SET   = 4'd6,
    A_SW_CLR   = 4'd7,
    A_CTRL     = 4'd8,
    A_EOI      = 4'd9,
    A_PRIO     = 4'd10
  } reg_addr_e;

  // A pending level beats the serviced level when level+1 > serviced+1.
  // An empty stack is treated as serviced level -1.
  function automatic logic level_wins(input logic [2:0] pend, input logic empty,
                                      input logic [2:0] top);
    logic [3:0] p_ext, t_ext;
    p_ext = {1'b0, pend} + 4'd1;
    t_ext = empty ? 4'd0 : ({1'b0, top} + 4'd1);
    return p_ext > t_ext;
  endfunction
endpackage

// File: rtl/dic_en_bank.sv
module dic_en_bank #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] en
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (set_we) en_q <= en_q | bits;
    else if (clr_we) en_q <= en_q & ~bits;
  end

  // position 0 carries the summary flag and never holds an enable
  assign en = {en_q[W-1:1], 1'b0};
endmodule

// File: rtl/dic_prio_table.sv
module dic_prio_table #(
  parameter int NSRC   = 28,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PRIO_W-1:0] lvl,
  input  logic [NSRC-1:0]   pend,
  output logic [PRIO_W-1:0] max_lvl,
  output logic              any
);
  logic [PRIO_W-1:0] lvl_q [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else if (wr && (int'(idx) < NSRC)) begin
      lvl_q[idx] <= lvl;
    end
  end

  always_comb begin
    max_lvl = '0;
    any     = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) begin
        any = 1'b1;
        if (lvl_q[i] > max_lvl) max_lvl = lvl_q[i];
      end
    end
  end
endmodule

// File: rtl/dic_nest_stack.sv
module dic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] din,
  output logic [CNT_W-1:0]  depth,
  output logic [PRIO_W-1:0] top,
  output logic              empty,
  output logic              full
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;

  assign empty = (cnt == '0);
  assign full  = (int'(cnt) == DEPTH);
  assign depth = cnt;
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (pop) begin
      if (!empty) cnt <= cnt - 1'b1;
    end else if (push && !full) begin
      mem[cnt] <= din;
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NSRC   = 28,
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hw_irq,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack,
  output logic              irq_out,
  output logic              fiq_out
);
  import dic_pkg::*;

  // named internal events, also used by the checker
  logic [NSRC-1:0]   active, irq_stat, fiq_stat, fiq_raw;
  logic [NSRC-1:0]   en [2];
  logic              soft_q, nest_en;
  logic              push_req, pop_req, irq_req, fiq_req;
  logic [PRIO_W-1:0] max_lvl, top_lvl;
  logic              any_irq, stk_empty, stk_full;
  logic [CNT_W-1:0]  depth;

  logic unused_ok;
  assign unused_ok = ^{hw_irq[1:0], wdata[DATA_W-1:NSRC]};

  // one enable bank per path: index 0 = IRQ, 1 = FIQ
  for (genvar p = 0; p < 2; p++) begin : g_path
    dic_en_bank #(.W(NSRC)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en && (addr == ADDR_W'(2 * p))),
      .clr_we (wr_en && (addr == ADDR_W'(2 * p + 1))),
      .bits   (wdata[NSRC-1:0]),
      .en     (en[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q  <= 1'b0;
      nest_en <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_SW_SET && wdata[1]) soft_q <= 1'b1;
      if (addr == A_SW_CLR && wdata[1]) soft_q <= 1'b0;
      if (addr == A_CTRL)               nest_en <= wdata[0];
    end
  end

  assign active   = {hw_irq[NSRC-1:2], soft_q, 1'b0};
  assign irq_stat = active & en[0];
  assign fiq_raw  = active & en[1];
  assign fiq_stat = {fiq_raw[NSRC-1:1], |fiq_raw[NSRC-1:1]};

  dic_prio_table #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_en && (addr == A_PRIO)),
    .idx     (wdata[IDX_W-1:0]),
    .lvl     (wdata[8 +: PRIO_W]),
    .pend    (irq_stat),
    .max_lvl (max_lvl),
    .any     (any_irq)
  );

  assign push_req = ack && nest_en && any_irq;
  assign pop_req  = wr_en && (addr == A_EOI);

  dic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_req),
    .pop   (pop_req),
    .din   (max_lvl),
    .depth (depth),
    .top   (top_lvl),
    .empty (stk_empty),
    .full  (stk_full)
  );

  assign irq_req = any_irq && (!nest_en || level_wins(max_lvl, stk_empty, top_lvl));
  assign fiq_req = fiq_stat[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= irq_req;
      fiq_out <= fiq_req;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_IRQ_SET, A_IRQ_CLR: rdata[NSRC-1:0] = en[0];
      A_FIQ_SET, A_FIQ_CLR: rdata[NSRC-1:0] = en[1];
      A_IRQ_STAT:           rdata[NSRC-1:0] = irq_stat;
      A_FIQ_STAT:           rdata[NSRC-1:0] = fiq_stat;
      A_SW_SET, A_SW_CLR:   rdata[1] = soft_q;
      A_CTRL:               rdata[0] = nest_en;
      A_PRIO:               rdata[7:0] = 8'({top_lvl, depth});
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
  parameter int NSRC  = 28,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            push_req,
  input logic            pop_req,
  input logic            nest_en,
  input logic [NSRC-1:0] irq_stat,
  input logic [NSRC-1:0] fiq_stat,
  input logic [CNT_W-1:0] depth,
  input logic            irq_out,
  input logic            fiq_out
);
  // R6
  fiq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fiq_stat) |=> fiq_out);
  // R6
  fiq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fiq_stat) |=> !fiq_out);
  // R7
  irq_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && (|irq_stat)) |=> irq_out);
  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_stat) |=> !irq_out);
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);
  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && int'(depth) == DEPTH) |=> int'(depth) == DEPTH);
  // R10
  no_nest_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && !wr_en) |=> $stable(depth));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.NSRC(NSRC), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .push_req (push_req),
  .pop_req  (pop_req),
  .nest_en  (nest_en),
  .irq_stat (irq_stat),
  .fiq_stat (fiq_stat),
  .depth    (depth),
  .irq_out  (irq_out),
  .fiq_out  (fiq_out)
);

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [27:0] hw_irq = '0;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 0;
  logic        irq_out, fiq_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  dual_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
    .irq_out(irq_out), .fiq_out(fiq_out));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  // let registered outputs follow the present status
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 fiq_out", 32'(fiq_out), 0);
    rd(0, d); chk("R1 irq en", d, 0);
    rd(2, d); chk("R1 fiq en", d, 0);
    rd(6, d); chk("R1 soft", d, 0);
    rd(8, d); chk("R1 nest", d, 0);
    rd(10, d); chk("R1 depth", d, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(0, 32'h0000_00F1); rd(0, d); chk("R2 set, bit0 held 0", d, 32'h0000_00F0);
    wr(0, 32'h0000_0000); rd(0, d); chk("R2 zero write keeps", d, 32'h0000_00F0);
    wr(1, 32'h0000_0030); rd(0, d); chk("R2 clear", d, 32'h0000_00C0);
    wr(1, 32'h0000_0000); rd(0, d); chk("R2 zero clear keeps", d, 32'h0000_00C0);
    wr(1, 32'h0FFF_FFFF);
    wr(2, 32'h0800_0004); rd(2, d); chk("R2 fiq set", d, 32'h0800_0004);
    wr(3, 32'h0FFF_FFFF); rd(2, d); chk("R2 fiq clear", d, 0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(0, 32'h0FFF_FFFE);
    wr(2, 32'h0FFF_FFFE);
    hw_irq = 28'h3; settle(); settle();
    rd(4, d); chk("R3 hw bits 1:0 ignored irq", d, 0);
    rd(5, d); chk("R3 hw bits 1:0 ignored fiq", d, 0);
    chk("R3 no irq_out", 32'(irq_out), 0);
    chk("R3 no fiq_out", 32'(fiq_out), 0);
    wr(6, 32'h2); settle();
    rd(4, d); chk("R3 R4 soft in irq stat", d, 32'h2);
    rd(5, d); chk("R3 R5 soft in fiq stat", d, 32'h3);
    chk("R7 irq_out soft", 32'(irq_out), 1);
    chk("R6 fiq_out soft", 32'(fiq_out), 1);
    wr(7, 32'h0); rd(6, d); chk("R3 clr with bit1=0 ignored", d, 32'h2);
    wr(7, 32'h2); settle();
    chk("R7 irq_out drops", 32'(irq_out), 0);
    chk("R6 fiq_out drops", 32'(fiq_out), 0);
    hw_irq = '0;
    wr(1, 32'h0FFF_FFFF); wr(3, 32'h0FFF_FFFF);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(0, 32'h0000_0F00);
    wr(2, 32'h0300_0000);
    hw_irq = 28'h0A0_0A00; settle();
    rd(4, d); chk("R4 irq stat", d, 32'h0000_0A00);
    rd(5, d); chk("R5 fiq stat none", d, 0);
    chk("R6 fiq idle", 32'(fiq_out), 0);
    hw_irq = 28'h200_0000; settle();
    rd(5, d); chk("R5 fiq stat with summary", d, 32'h0200_0001);
    rd(4, d); chk("R4 irq stat masked", d, 0);
    chk("R6 fiq_out", 32'(fiq_out), 1);
    chk("R7 irq_out off", 32'(irq_out), 0);
    hw_irq = '0;
    wr(1, 32'h0FFF_FFFF); wr(3, 32'h0FFF_FFFF);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(10, {21'd0, 3'd2, 3'd0, 5'd5});
    wr(10, {21'd0, 3'd5, 3'd0, 5'd9});
    wr(0, 32'h0000_0220);
    pulse_ack(); rd(10, d); chk("R10 ack ignored with nesting off", d, 0);
    hw_irq = 28'h20; pulse_ack(); rd(10, d); chk("R10 ack with pending, nest off", d, 0);
    wr(8, 32'h1); rd(8, d); chk("R8 nest enabled", d, 1);
    settle(); chk("R8 empty stack accepts", 32'(irq_out), 1);
    pulse_ack(); rd(10, d); chk("R9 push level 2", d, {25'd0, 3'd2, 4'd1});
    settle(); chk("R8 same level blocked", 32'(irq_out), 0);
    hw_irq = 28'h220; settle(); settle();
    chk("R8 higher level preempts", 32'(irq_out), 1);
    pulse_ack(); rd(10, d); chk("R9 push level 5", d, {25'd0, 3'd5, 4'd2});
    settle(); chk("R8 blocked at level 5", 32'(irq_out), 0);
    wr(9, 0); rd(10, d); chk("R9 pop", d, {25'd0, 3'd2, 4'd1});
    settle(); chk("R8 re-armed after pop", 32'(irq_out), 1);
    for (int i = 0; i < 9; i++) pulse_ack();
    rd(10, d); chk("R9 stack saturates at 8", d[3:0], 8);
    for (int i = 0; i < 8; i++) wr(9, 0);
    rd(10, d); chk("R9 drained", d, 0);
    wr(9, 0); rd(10, d); chk("R9 pop on empty ignored", d, 0);
    hw_irq = '0; wr(8, 0); wr(1, 32'h0FFF_FFFF);
  endtask

  initial begin
    #9 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_soft();
    t_status();
    t_nest();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule